// File: doc/BRIEF.md
# UART Modem Loopback Controller

This block sits between a UART core and its package pins. In normal operation it passes the serial transmit line from the core to the pin, carries the serial receive pin into the core through a synchronizer, drives the four modem-control outputs from the modem control bits, and presents the synchronized modem inputs to software as a modem status byte. Each of the four status bits has a sticky change flag. A read of the status byte clears the flags.

A control bit puts the block into loopback, which supports on-board self-test. In loopback the core's transmit line feeds its own receive input, and the receive pin is ignored. The transmit pin idles high and the modem-control pins are driven inactive. The four modem status inputs are taken from the modem control bits instead of from the pins. The interrupt output enable is dropped, so software has to poll. All outputs come from registers.

Top module: `uart_loopback_ctrl`

## Requirements
- R1: When `ctrl[4]` (loopback) is 1, `core_rxd` equals the value `core_txd` had one clock earlier, and `pin_rxd` has no effect on `core_rxd`.
- R2: When loopback is on, `pin_txd` is 1 and `pin_dtr_n`, `pin_rts_n`, `pin_op1_n` and `pin_op2_n` are all 1 one clock later, whatever the values of `core_txd` and `ctrl[3:0]`.
- R3: When loopback is off, one clock later `pin_txd` equals `core_txd` and each modem output pin is the inverse of its control bit: `pin_dtr_n`=~`ctrl[0]`, `pin_rts_n`=~`ctrl[1]`, `pin_op1_n`=~`ctrl[2]`, `pin_op2_n`=~`ctrl[3]`.
- R4: When loopback is off, `core_rxd` follows `pin_rxd` SYNC_STAGES+1 clocks after a change, and not earlier.
- R5: When loopback is off, status bits `msr_q[7:4]` are {~`pin_dcd_n`, ~`pin_ri_n`, ~`pin_dsr_n`, ~`pin_cts_n`}. A pin change appears SYNC_STAGES+1 clocks later, and not earlier.
- R6: When loopback is on, status bit 4 (CTS) is `ctrl[1]`, bit 5 (DSR) is `ctrl[0]`, bit 7 (CD) is `ctrl[3]` and bit 6 (RI) is `ctrl[2]`, one clock after the control change. The four modem input pins have no effect.
- R7: `msr_q[0]`, `msr_q[1]` and `msr_q[3]` are set when status bit 4, 5 or 7 respectively changes value in either direction. They stay set until cleared.
- R8: `msr_q[2]` is set only when status bit 6 (RI) goes from 1 to 0. A 0-to-1 change leaves it unchanged.
- R9: A one-clock `msr_rd` pulse clears `msr_q[3:0]` at the next clock. A status change arriving in that same clock still sets its flag.
- R10: One clock after the loopback bit changes, `irq_oe` is 0 in loopback and 1 otherwise. `irq_o` equals `core_irq` delayed one clock.
- R11: During synchronous reset, `msr_q`=0, `pin_txd`=1, all modem output pins are 1, `core_rxd`=1, `irq_o`=0 and `irq_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 5 | Modem control bits: 0 DTR, 1 RTS, 2 OP1, 3 OP2, 4 loopback enable |
| core_txd | input | 1 | Serial data from the UART transmitter |
| core_rxd | output | 1 | Serial data to the UART receiver |
| pin_txd | output | 1 | Transmit pin |
| pin_rxd | input | 1 | Receive pin (asynchronous) |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_dcd_n | input | 1 | Carrier-detect pin, active low |
| pin_ri_n | input | 1 | Ring-indicator pin, active low |
| pin_dtr_n | output | 1 | Data-terminal-ready pin, active low |
| pin_rts_n | output | 1 | Request-to-send pin, active low |
| pin_op1_n | output | 1 | General output 1 pin, active low |
| pin_op2_n | output | 1 | General output 2 pin, active low |
| msr_rd | input | 1 | Status read strobe; clears the change flags |
| msr_q | output | 8 | Status: 7 CD, 6 RI, 5 DSR, 4 CTS, 3 CD changed, 2 RI trailing edge, 1 DSR changed, 0 CTS changed |
| core_irq | input | 1 | Interrupt request from the UART core |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable (0 = high impedance) |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. This makes the three-clock latency from a pin to the status byte and to `core_rxd` visible. The bench samples both just before and at the clock where the change appears. The bench times a pin change to land in the same clock as a status read, which exercises the case where a set and a clear of a change flag occur together. It also drives the modem input pins active while loopback is on, to show that they are ignored.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int CTL_W    = 5;
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OP1  = 2;
  localparam int CTL_OP2  = 3;
  localparam int CTL_LOOP = 4;
  localparam int MDM_W    = 4;

  // Status order matches the high nibble of the status byte: CD, RI, DSR, CTS
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } modem_t;

  localparam int RI_IDX = 2;
endpackage

// File: rtl/lb_sync.sv
module lb_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[s] <= RST_VAL;
        else     st[s] <= st[s-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/lb_route.sv
module lb_route (
  input  logic       clk,
  input  logic       rst,
  input  logic       loop_en,
  input  logic [3:0] ctl_out,
  input  logic       core_txd,
  input  logic       rxd_sync,
  input  logic       core_irq,
  output logic       pin_txd,
  output logic       core_rxd,
  output logic       pin_dtr_n,
  output logic       pin_rts_n,
  output logic       pin_op1_n,
  output logic       pin_op2_n,
  output logic       irq_o,
  output logic       irq_oe
);
  import uart_lb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_txd   <= 1'b1;
      core_rxd  <= 1'b1;
      pin_dtr_n <= 1'b1;
      pin_rts_n <= 1'b1;
      pin_op1_n <= 1'b1;
      pin_op2_n <= 1'b1;
      irq_o     <= 1'b0;
      irq_oe    <= 1'b1;
    end else begin
      pin_txd   <= loop_en ? 1'b1 : core_txd;
      core_rxd  <= loop_en ? core_txd : rxd_sync;
      pin_dtr_n <= loop_en | ~ctl_out[CTL_DTR];
      pin_rts_n <= loop_en | ~ctl_out[CTL_RTS];
      pin_op1_n <= loop_en | ~ctl_out[CTL_OP1];
      pin_op2_n <= loop_en | ~ctl_out[CTL_OP2];
      irq_o     <= core_irq;
      irq_oe    <= ~loop_en;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= ~rst;

  assert_loop_rx_R1: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(loop_en) |-> core_rxd == $past(core_txd));

  assert_loop_idle_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(loop_en) |->
      pin_txd && pin_dtr_n && pin_rts_n && pin_op1_n && pin_op2_n);

  assert_norm_tx_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(loop_en) |-> pin_txd == $past(core_txd));

  assert_irq_en_R10: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> irq_oe == !$past(loop_en));
endmodule

// File: rtl/lb_msr.sv
module lb_msr (
  input  logic                 clk,
  input  logic                 rst,
  input  uart_lb_pkg::modem_t  stat_in,
  input  logic                 rd,
  output logic [7:0]           msr_q
);
  import uart_lb_pkg::*;

  logic [MDM_W-1:0] cur, nxt, chg, flag;

  assign nxt = stat_in;
  assign cur = msr_q[7:4];

  generate
    for (genvar i = 0; i < MDM_W; i++) begin : g_bit
      if (i == RI_IDX) begin : g_trail
        assign chg[i] = cur[i] & ~nxt[i];
      end else begin : g_any
        assign chg[i] = cur[i] ^ nxt[i];
      end
      assign flag[i] = (msr_q[i] & ~rd) | chg[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) msr_q <= '0;
    else     msr_q <= {nxt, flag};
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= ~rst;

  assert_cts_delta_R7: assert property (@(posedge clk) disable iff (rst)
    past_ok && ($past(msr_q[4]) != msr_q[4]) |-> msr_q[0]);

  assert_ri_trail_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $rose(msr_q[2]) |-> $past(msr_q[6]) && !msr_q[6]);

  assert_read_clr_R9: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rd) && (msr_q[7:4] == $past(msr_q[7:4])) |-> msr_q[3:0] == 4'b0);
endmodule

// File: rtl/uart_loopback_ctrl.sv
module uart_loopback_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] ctrl,
  input  logic       core_txd,
  output logic       core_rxd,
  output logic       pin_txd,
  input  logic       pin_rxd,
  input  logic       pin_cts_n,
  input  logic       pin_dsr_n,
  input  logic       pin_dcd_n,
  input  logic       pin_ri_n,
  output logic       pin_dtr_n,
  output logic       pin_rts_n,
  output logic       pin_op1_n,
  output logic       pin_op2_n,
  input  logic       msr_rd,
  output logic [7:0] msr_q,
  input  logic       core_irq,
  output logic       irq_o,
  output logic       irq_oe
);
  import uart_lb_pkg::*;

  localparam int IN_W = MDM_W + 1;

  logic [IN_W-1:0] raw_in, syn_in;
  logic            loop_en;
  modem_t          ext_stat, lb_stat, use_stat;

  assign raw_in  = {pin_rxd, pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n};
  assign loop_en = ctrl[CTL_LOOP];

  lb_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  assign ext_stat = ~syn_in[MDM_W-1:0];

  assign lb_stat.cts = ctrl[CTL_RTS];
  assign lb_stat.dsr = ctrl[CTL_DTR];
  assign lb_stat.dcd = ctrl[CTL_OP2];
  assign lb_stat.ri  = ctrl[CTL_OP1];

  assign use_stat = loop_en ? lb_stat : ext_stat;

  lb_route u_route (
    .clk(clk), .rst(rst), .loop_en(loop_en), .ctl_out(ctrl[3:0]),
    .core_txd(core_txd), .rxd_sync(syn_in[IN_W-1]), .core_irq(core_irq),
    .pin_txd(pin_txd), .core_rxd(core_rxd),
    .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n),
    .pin_op1_n(pin_op1_n), .pin_op2_n(pin_op2_n),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  lb_msr u_msr (
    .clk(clk), .rst(rst), .stat_in(use_stat), .rd(msr_rd), .msr_q(msr_q)
  );
endmodule

// File: tb/uart_loopback_ctrl_bench.sv
module uart_loopback_ctrl_bench;
  localparam time PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] ctrl;
  logic       core_txd, core_rxd, pin_txd, pin_rxd;
  logic       pin_cts_n, pin_dsr_n, pin_dcd_n, pin_ri_n;
  logic       pin_dtr_n, pin_rts_n, pin_op1_n, pin_op2_n;
  logic       msr_rd, core_irq, irq_o, irq_oe;
  logic [7:0] msr_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_loopback_ctrl u_uart_loopback_ctrl (
    .clk(clk), .rst(rst), .ctrl(ctrl), .core_txd(core_txd), .core_rxd(core_rxd),
    .pin_txd(pin_txd), .pin_rxd(pin_rxd), .pin_cts_n(pin_cts_n),
    .pin_dsr_n(pin_dsr_n), .pin_dcd_n(pin_dcd_n), .pin_ri_n(pin_ri_n),
    .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n), .pin_op1_n(pin_op1_n),
    .pin_op2_n(pin_op2_n), .msr_rd(msr_rd), .msr_q(msr_q),
    .core_irq(core_irq), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mpins();
    return {pin_op2_n, pin_op1_n, pin_rts_n, pin_dtr_n};
  endfunction

  task automatic rd_clear();
    msr_rd = 1'b1; step(1); msr_rd = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; ctrl = 5'b0; core_txd = 1'b1; pin_rxd = 1'b1;
    pin_cts_n = 1'b1; pin_dsr_n = 1'b1; pin_dcd_n = 1'b1; pin_ri_n = 1'b1;
    msr_rd = 1'b0; core_irq = 1'b0;
    step(3);
    chk("R11 msr", msr_q, 8'h00);
    chk("R11 txd/rxd", {6'b0, pin_txd, core_rxd}, 8'h03);
    chk("R11 modem pins", {4'b0, mpins()}, 8'h0f);
    chk("R11 irq", {6'b0, irq_o, irq_oe}, 8'h01);
    rst = 1'b0; step(1);
  endtask

  task automatic t_normal_out();
    core_txd = 1'b0; ctrl = 5'b0_1010; core_irq = 1'b1;
    step(1);
    chk("R3 txd", {7'b0, pin_txd}, 8'h00);
    chk("R3 modem pins", {4'b0, mpins()}, 8'h05);
    chk("R10 irq follows", {6'b0, irq_o, irq_oe}, 8'h03);
    core_txd = 1'b1; ctrl = 5'b0_0101; core_irq = 1'b0;
    step(1);
    chk("R3 txd high", {7'b0, pin_txd}, 8'h01);
    chk("R3 modem pins 2", {4'b0, mpins()}, 8'h0a);
    ctrl = 5'b0;
  endtask

  task automatic t_sync_latency();
    pin_rxd = 1'b0; pin_cts_n = 1'b0;
    step(2);
    chk("R4 rxd not early", {7'b0, core_rxd}, 8'h01);
    chk("R5 cts not early", {7'b0, msr_q[4]}, 8'h00);
    step(1);
    chk("R4 rxd arrives", {7'b0, core_rxd}, 8'h00);
    chk("R5 cts arrives", {7'b0, msr_q[4]}, 8'h01);
    chk("R7 dcts set", {7'b0, msr_q[0]}, 8'h01);
    pin_rxd = 1'b1;
    step(3);
    chk("R4 rxd back", {7'b0, core_rxd}, 8'h01);
  endtask

  task automatic t_deltas();
    rd_clear();
    chk("R9 cleared", msr_q, 8'h10);
    pin_dsr_n = 1'b0; pin_dcd_n = 1'b0;
    step(4);
    chk("R7 dsr/dcd", msr_q, 8'hba);
    rd_clear();
    pin_ri_n = 1'b0;
    step(4);
    chk("R8 ri rise no flag", msr_q, 8'hf0);
    pin_ri_n = 1'b1;
    step(4);
    chk("R8 ri fall flag", msr_q, 8'hb4);
    rd_clear();
    chk("R9 clear", msr_q, 8'hb0);
    pin_cts_n = 1'b1; step(4);
    chk("R7 cts fall", msr_q, 8'ha1);
    // change reaches status in the same clock as the read
    pin_dsr_n = 1'b1;
    step(2);
    msr_rd = 1'b1; step(1); msr_rd = 1'b0;
    chk("R9 collision keeps ddsr", msr_q, 8'h82);
    pin_dcd_n = 1'b1; step(4);
    rd_clear();
    chk("R5 all idle", msr_q, 8'h00);
  endtask

  task automatic t_loopback();
    ctrl = 5'b1_0000; core_txd = 1'b0; core_irq = 1'b1;
    step(1);
    chk("R2 idle pins", {3'b0, pin_txd, mpins()}, 8'h1f);
    chk("R10 oe off", {7'b0, irq_oe}, 8'h00);
    chk("R1 rx from tx", {7'b0, core_rxd}, 8'h00);
    pin_rxd = 1'b0; core_txd = 1'b1;
    step(4);
    chk("R1 pin rxd ignored", {7'b0, core_rxd}, 8'h01);
    pin_rxd = 1'b1;
    ctrl = 5'b1_0010; step(1);
    chk("R6 cts from rts", msr_q, 8'h11);
    ctrl = 5'b1_0011; step(1);
    chk("R6 dsr from dtr", msr_q, 8'h33);
    ctrl = 5'b1_1011; step(1);
    chk("R6 cd from op2", msr_q, 8'hbb);
    chk("R2 pins stay idle", {4'b0, mpins()}, 8'h0f);
    ctrl = 5'b1_1111; step(1);
    chk("R6 ri from op1", msr_q, 8'hfb);
    rd_clear();
    pin_cts_n = 1'b0; pin_dsr_n = 1'b0; pin_dcd_n = 1'b0; pin_ri_n = 1'b0;
    ctrl = 5'b1_0000; step(1);
    chk("R6 pins ignored", msr_q, 8'h0f);
    step(4);
    chk("R6 pins still ignored", msr_q, 8'h0f);
    pin_cts_n = 1'b1; pin_dsr_n = 1'b1; pin_dcd_n = 1'b1; pin_ri_n = 1'b1;
    step(3);
    ctrl = 5'b0; core_irq = 1'b0; step(1);
    chk("R10 oe back", {6'b0, irq_o, irq_oe}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_normal_out();
    t_sync_latency();
    t_deltas();
    t_loopback();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule